// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sorts the interrupt requests of a small 8-bit CPU core into one winner and hands the core a vector address. Six sources feed it: two active-low external pins, overflow flags from three timers, and a serial port flag. Software programs three registers through a simple write/read port. The enable register carries a master switch and one gate per source. The priority register places each source in a high or a low level. The external type register chooses level or falling-edge detection for each pin.

When a request survives enabling and the nesting rule, the controller raises `irq_valid` with the vector address and the level of the winner. The core answers with a one-cycle acknowledge. The acknowledge marks that level as in service and clears any request flag that hardware clears on vectoring. A one-cycle return strobe later closes the innermost service. A running service blocks requests of its own level or of a lower level. Within a level, a fixed order picks between requests that arrive together.

Source index (bit position in the enable and priority registers): 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. Register select: 0 enable, 1 priority, 2 external type (bit 0 for pin 0, bit 1 for pin 1).

Top module: `intc_two_level`

## Requirements
- R1: After reset, all three registers read 0, `in_service` is 00, and `irq_valid` is 0.
- R2: While enable bit 7 (global) is 0, `irq_valid` stays 0 whatever the per-source enables hold.
- R3: Enable bits 0 to 5 gate sources 0 to 5. Bit 6 is reserved: writes to it are dropped and it reads 0.
- R4: Priority bit i set to 1 puts source i in the high level, and 0 puts it in the low level. Bits 7 and 6 read 0.
- R5: The vector for source i is 0003h + 8*i, which gives 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh.
- R6: Among requests of the same level, the lowest source index wins.
- R7: A high-level request preempts a low-level service. While the low level is in service, no low-level request is presented. While the high level is in service, nothing is presented.
- R8: With type bit 0, an external pin requests while its sampled value is low. The request appears one clock after the pin falls and goes away one clock after the pin rises. It is not latched.
- R9: With type bit 1, a sampled 1-to-0 transition on the pin sets a request flag, visible two clocks after the fall. The flag persists after the pin rises and is cleared when that source is acknowledged.
- R10: A one-cycle pulse on `tmr_ovf[0]` (timer 0) or `tmr_ovf[1]` (timer 1) latches a request flag. The acknowledge of that source clears the flag.
- R11: The serial and timer 2 requests follow their inputs directly and are not cleared by an acknowledge.
- R12: An acknowledge while `irq_valid` is 1 sets `in_service` bit `irq_level`. A return strobe clears bit 1 if it is set, otherwise bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 priority, 2 external type |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Overflow pulses of timers 0 and 1 |
| ser_flag | input | 1 | Serial port request level |
| tmr2_flag | input | 1 | Timer 2 request level |
| irq_valid | output | 1 | A request is presented to the core |
| irq_vector | output | 16 | Vector address of the winner |
| irq_level | output | 1 | Level of the winner, 1 is high |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_reti | input | 1 | Return from the innermost service |
| in_service | output | 2 | Bit 1 high level in service, bit 0 low level in service |

## Verification
The assertions assume that the core sends acknowledge and return strobes as single-cycle pulses and never sends both in the same cycle. They also assume that a return strobe arrives only while some level is in service, so that the two in-service bits always describe proper nesting. The directed tasks keep to this. Each strobe is raised for one cycle between falling clock edges, acknowledges are sent only when `irq_valid` is 1, and every return matches an earlier acknowledge. Each scenario starts from a fresh reset, so no state is carried over from one to the next.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC      = 6;
    localparam int NEXT      = 2;
    localparam int NTMR      = 2;
    localparam int DW        = 8;
    localparam int VW        = 16;
    localparam int IDXW      = $clog2(NSRC);
    localparam int GLB_BIT   = 7;
    localparam int VEC_SHIFT = 3;
    localparam logic [VW-1:0] VEC_BASE = 16'h0003;

    localparam int SRC_SER  = 4;
    localparam int SRC_TMR2 = 5;

    localparam logic [1:0] SEL_EN   = 2'd0;
    localparam logic [1:0] SEL_PRIO = 2'd1;
    localparam logic [1:0] SEL_TYPE = 2'd2;

    typedef struct packed {
        logic [DW-1:0]   en;
        logic [NSRC-1:0] prio;
        logic [NEXT-1:0] etype;
        logic [NTMR-1:0] tflag;
        logic [1:0]      insvc;
    } ctl_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic flag;
    } ext_t;
endpackage

// File: rtl/intc_ext_req.sv
module intc_ext_req
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    ext_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_n;
        st_d.s2 = st_q.s1;
        if (edge_mode && st_q.s2 && !st_q.s1)
            st_d.flag = 1'b1;
        else if (clr || !edge_mode)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign req = edge_mode ? st_q.flag : !st_q.s1;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  prio,
    input  logic [1:0]    insvc,
    output logic          valid,
    output logic [IW-1:0] idx,
    output logic          level
);
    logic [N-1:0] hi_pend, lo_pend, pick;

    always_comb begin
        hi_pend = pend & prio;
        lo_pend = pend & ~prio;
        level   = 1'b0;
        pick    = '0;
        if (!insvc[1] && |hi_pend) begin
            level = 1'b1;
            pick  = hi_pend;
        end else if (!insvc[1] && !insvc[0]) begin
            pick  = lo_pend;
        end
        valid = |pick;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pick[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NTMR-1:0] tmr_ovf,
    input  logic          ser_flag,
    input  logic          tmr2_flag,
    output logic          irq_valid,
    output logic [VW-1:0] irq_vector,
    output logic          irq_level,
    input  logic          irq_ack,
    input  logic          irq_reti,
    output logic [1:0]    in_service
);
    ctl_t st_d, st_q;

    logic [NSRC-1:0] req, pend;
    logic [IDXW-1:0] win;
    logic            take;

    assign take = irq_ack && irq_valid;

    generate
        for (genvar e = 0; e < NEXT; e++) begin : g_ext
            logic clr_e;
            assign clr_e = take && (win == IDXW'(2 * e));
            intc_ext_req i_ext (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_n     (ext_n[e]),
                .edge_mode (st_q.etype[e]),
                .clr       (clr_e),
                .req       (req[2 * e])
            );
        end
        for (genvar t = 0; t < NTMR; t++) begin : g_tmr
            assign req[2 * t + 1] = st_q.tflag[t];
        end
    endgenerate

    assign req[SRC_SER]  = ser_flag;
    assign req[SRC_TMR2] = tmr2_flag;
    assign pend = req & st_q.en[NSRC-1:0] & {NSRC{st_q.en[GLB_BIT]}};

    intc_arbiter #(.N(NSRC), .IW(IDXW)) i_arb (
        .pend  (pend),
        .prio  (st_q.prio),
        .insvc (st_q.insvc),
        .valid (irq_valid),
        .idx   (win),
        .level (irq_level)
    );

    assign irq_vector = VEC_BASE + (VW'(win) << VEC_SHIFT);
    assign in_service = st_q.insvc;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            case (reg_sel)
                SEL_EN: begin
                    st_d.en = reg_wdata;
                    st_d.en[DW-2] = 1'b0;
                end
                SEL_PRIO: st_d.prio  = reg_wdata[NSRC-1:0];
                SEL_TYPE: st_d.etype = reg_wdata[NEXT-1:0];
                default:  ;
            endcase
        end
        for (int t = 0; t < NTMR; t++) begin
            if (tmr_ovf[t])
                st_d.tflag[t] = 1'b1;
            else if (take && win == IDXW'(2 * t + 1))
                st_d.tflag[t] = 1'b0;
        end
        if (irq_reti) begin
            if (st_q.insvc[1]) st_d.insvc[1] = 1'b0;
            else               st_d.insvc[0] = 1'b0;
        end
        if (take) st_d.insvc[irq_level] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_EN:   reg_rdata = st_q.en;
            SEL_PRIO: reg_rdata = DW'(st_q.prio);
            SEL_TYPE: reg_rdata = DW'(st_q.etype);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          glb_en,
    input logic          irq_valid,
    input logic          irq_level,
    input logic [VW-1:0] irq_vector,
    input logic          irq_ack,
    input logic          irq_reti,
    input logic [1:0]    in_service
);
    assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq_valid);

    assert_high_blocks_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_service[1] |-> !irq_valid);

    assert_low_only_preempted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service[0] && irq_valid) |-> irq_level);

    assert_vector_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector[2:0] == 3'd3 && irq_vector[VW-1:6] == '0
                       && irq_vector[5:3] < 3'(NSRC)));

    assert_ack_marks_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid) |=> in_service[$past(irq_level)]);

    assert_reti_high_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reti && !irq_ack && in_service == 2'b11) |=> in_service == 2'b01);
endmodule

bind intc_two_level intc_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_en     (st_q.en[intc_pkg::GLB_BIT]),
    .irq_valid  (irq_valid),
    .irq_level  (irq_level),
    .irq_vector (irq_vector),
    .irq_ack    (irq_ack),
    .irq_reti   (irq_reti),
    .in_service (in_service)
);

// File: tb/test_intc_two_level.sv
module test_intc_two_level;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_flag = 1'b0;
    logic        tmr2_flag = 1'b0;
    logic        irq_valid;
    logic [15:0] irq_vector;
    logic        irq_level;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;
    logic [1:0]  in_service;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intc_two_level i_intc_two_level (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_n(ext_n),
        .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .tmr2_flag(tmr2_flag),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
        .irq_ack(irq_ack), .irq_reti(irq_reti), .in_service(in_service)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ext_n = 2'b11; tmr_ovf = 2'b00; ser_flag = 1'b0;
        tmr2_flag = 1'b0; irq_ack = 1'b0; irq_reti = 1'b0; reg_we = 1'b0;
        reg_sel = 2'd0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input string tag, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic pulse_tmr(input int t);
        tmr_ovf[t] = 1'b1;
        @(negedge clk);
        tmr_ovf[t] = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic reti();
        irq_reti = 1'b1;
        @(negedge clk);
        irq_reti = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        rd(2'd0, "R1 enable", 8'h00);
        rd(2'd1, "R1 priority", 8'h00);
        rd(2'd2, "R1 type", 8'h00);
        chk("R1 valid", 32'(irq_valid), 0);
        chk("R1 in_service", 32'(in_service), 0);
    endtask

    task automatic t_global();
        do_reset();
        wr(2'd0, 8'h02);
        pulse_tmr(0);
        chk("R2 no global", 32'(irq_valid), 0);
        wr(2'd0, 8'hC2);
        rd(2'd0, "R3 bit6 reserved", 8'h82);
        chk("R2 global on", 32'(irq_valid), 1);
        chk("R5 timer0 vector", 32'(irq_vector), 32'h000B);
        ack();
        chk("R12 low in service", 32'(in_service), 32'b01);
        reti();
        chk("R10 timer0 flag cleared", 32'(irq_valid), 0);
        chk("R12 reti clears low", 32'(in_service), 0);
        wr(2'd0, 8'h80);
        pulse_tmr(1);
        chk("R3 timer1 disabled", 32'(irq_valid), 0);
        wr(2'd0, 8'h88);
        chk("R3 timer1 enabled", 32'(irq_vector), 32'h001B);
    endtask

    task automatic t_order();
        do_reset();
        wr(2'd0, 8'hBF);
        tmr2_flag = 1'b1; @(negedge clk);
        chk("R5 timer2 vector", 32'(irq_vector), 32'h002B);
        ser_flag = 1'b1; @(negedge clk);
        chk("R6 serial over timer2", 32'(irq_vector), 32'h0023);
        pulse_tmr(1);
        chk("R6 timer1 over serial", 32'(irq_vector), 32'h001B);
        ext_n[1] = 1'b0; @(negedge clk);
        chk("R6 ext1 over timer1", 32'(irq_vector), 32'h0013);
        pulse_tmr(0);
        chk("R6 timer0 over ext1", 32'(irq_vector), 32'h000B);
        ext_n[0] = 1'b0; @(negedge clk);
        chk("R6 ext0 first", 32'(irq_vector), 32'h0003);
        chk("R6 level low", 32'(irq_level), 0);
    endtask

    task automatic t_level();
        do_reset();
        wr(2'd0, 8'h81);
        ext_n[0] = 1'b0;
        #1;
        chk("R8 not before sample", 32'(irq_valid), 0);
        @(negedge clk);
        chk("R8 level request", 32'(irq_valid), 1);
        ext_n[0] = 1'b1; @(negedge clk);
        chk("R8 not latched", 32'(irq_valid), 0);
    endtask

    task automatic t_edge();
        do_reset();
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h81);
        ext_n[0] = 1'b0; @(negedge clk);
        chk("R9 one clock after fall", 32'(irq_valid), 0);
        @(negedge clk);
        chk("R9 two clocks after fall", 32'(irq_valid), 1);
        ext_n[0] = 1'b1; @(negedge clk); @(negedge clk);
        chk("R9 flag persists", 32'(irq_valid), 1);
        ack();
        chk("R9 in service", 32'(in_service), 32'b01);
        reti();
        chk("R9 flag cleared on ack", 32'(irq_valid), 0);
    endtask

    task automatic t_nest();
        do_reset();
        wr(2'd1, 8'hFF);
        rd(2'd1, "R4 reserved bits", 8'h3F);
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h9B);
        pulse_tmr(1);
        chk("R4 low level winner", 32'(irq_level), 0);
        ack();
        chk("R7 low blocks itself", 32'(irq_valid), 0);
        pulse_tmr(0);
        chk("R7 low blocks low", 32'(irq_valid), 0);
        ser_flag = 1'b1; @(negedge clk);
        chk("R7 high preempts", 32'(irq_vector), 32'h0023);
        chk("R4 high level", 32'(irq_level), 1);
        ack();
        chk("R12 both in service", 32'(in_service), 32'b11);
        chk("R7 high blocks all", 32'(irq_valid), 0);
        reti();
        chk("R12 high cleared first", 32'(in_service), 32'b01);
        chk("R11 serial not cleared", 32'(irq_vector), 32'h0023);
        chk("R11 serial still valid", 32'(irq_valid), 1);
        ser_flag = 1'b0; @(negedge clk);
        chk("R7 low still blocked", 32'(irq_valid), 0);
        reti();
        chk("R12 all clear", 32'(in_service), 0);
        chk("R10 timer0 waits", 32'(irq_vector), 32'h000B);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_global();
        t_order();
        t_level();
        t_edge();
        t_nest();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule